// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers single-cycle event pulses from internal sources into sticky status latches arranged in two levels. It drives one active-low interrupt request line toward a processor. The second level holds six group sources: two general purpose timers, a bus-address trap and three user-defined traps. The top level holds fifteen independent source bits. Its remaining bit, position 9, is a summary that reads as the OR of the six group bits.

Software uses a registered read port to find and clear the sources. Each level has two views of the same word. The mirror view returns the word and changes nothing. The clearing view returns the same word and clears the bits it returned. A handler reads the top word first. If bit 9 is set, it reads the group word to identify the source. The request line stays low until every latch at both levels is empty.

There are two small state machines:
- The read-port machine has the states `RP_IDLE` and `RP_RESP`. It takes `RP_IDLE -> RP_RESP` on a read strobe, `RP_RESP -> RP_RESP` on a back-to-back strobe, and `RP_RESP -> RP_IDLE` when no strobe arrives.
- The request machine has the states `RQ_QUIET` and `RQ_ASSERTED`. It takes `RQ_QUIET -> RQ_ASSERTED` when any latch will hold a pending bit after the next edge, and `RQ_ASSERTED -> RQ_QUIET` when none will.

Top module: `hisa_irq_aggregator`

## Requirements
- R1: After reset, all latches are clear, `irq_n` is high and `rd_valid` is low.
- R2: A pulse on `grp_evt[i]` sets group bit i. The bits are assigned as follows: bit 0 is timer 1, bit 1 is timer 2, bit 2 is the bus trap, and bits 3, 4 and 5 are user traps 1, 2 and 3. The group word reads at address 04h (mirror) and at 06h (clearing), and bits [15:6] of it read as zero.
- R3: A pulse on `top_evt[k]`, for k not equal to 9, sets top bit k. The top word reads at address 00h (mirror) and at 02h (clearing). Its bit 9 reads as 1 exactly when any group bit is set.
- R4: A read of the mirror view at 00h or 04h returns the word and clears nothing.
- R5: A read at 02h returns the top word and clears top bits other than 9. Bit 9 stays set while any group bit is set.
- R6: A read at 06h returns the group word and clears it. After that, top bit 9 reads 0 unless a new group event has arrived.
- R7: When an event pulse lands in the same cycle as a clearing read of its bit, the bit stays set. The data returned by that read shows the value from before the event.
- R8: `rd_valid` and `rd_data` appear exactly one clock after `rd_en`. The clear takes effect on that same edge. Reads may be issued back to back.
- R9: `irq_n` goes low on the edge that latches the first pending bit. It stays low while any bit at either level is set, and it goes high on the edge that clears the last one.
- R10: `top_evt[9]` has no effect: it sets no bit and does not drive the request.
- R11: A read at any other address returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_evt | input | 16 | Event pulses for independent top-level sources (bit 9 ignored) |
| grp_evt | input | 6 | Event pulses for the timer and trap group |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_valid | output | 1 | Read data valid, one clock after the strobe |
| rd_data | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Clearing the top word while group bits remain set. A design that latched the summary bit would drop bit 9 here and hide a pending timer.
- An event that collides with a clearing read. A design that gave the clear priority would lose the event, and the request line would release early.
- Mirror reads and reads at unmapped addresses. A sloppy address decode would clear status on one of these reads.
- An event pulse on the summary position of the top input. A design that does not mask that input would raise a phantom request.

// File: rtl/hisa_pkg.sv
package hisa_pkg;

    localparam int STAT_W  = 16;
    localparam int GRP_W   = 6;
    localparam int GRP_BIT = 9;
    localparam int ADDR_W  = 8;

    // Read-port offsets; bit 1 selects the clearing view, bit 2 the group level
    localparam int OFF_TOP_MIR = 'h00;
    localparam int OFF_TOP_CLR = 'h02;
    localparam int OFF_GRP_MIR = 'h04;
    localparam int OFF_GRP_CLR = 'h06;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TOP  = 2'd1,
        TGT_GRP  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic clr;
    } rd_sel_t;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rp_state_e;

    typedef enum logic {
        RQ_QUIET    = 1'b0,
        RQ_ASSERTED = 1'b1
    } rq_state_e;

endpackage

// File: rtl/hisa_rd_decode.sv
module hisa_rd_decode
    import hisa_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output rd_sel_t       sel
);

    localparam logic [AW-1:0] A_TOP_MIR = AW'(OFF_TOP_MIR);
    localparam logic [AW-1:0] A_TOP_CLR = AW'(OFF_TOP_CLR);
    localparam logic [AW-1:0] A_GRP_MIR = AW'(OFF_GRP_MIR);
    localparam logic [AW-1:0] A_GRP_CLR = AW'(OFF_GRP_CLR);

    always_comb begin
        sel.tgt = TGT_NONE;
        sel.clr = 1'b0;
        if (rd_en) begin
            if (rd_addr == A_TOP_MIR) begin
                sel.tgt = TGT_TOP;
            end else if (rd_addr == A_TOP_CLR) begin
                sel.tgt = TGT_TOP;
                sel.clr = 1'b1;
            end else if (rd_addr == A_GRP_MIR) begin
                sel.tgt = TGT_GRP;
            end else if (rd_addr == A_GRP_CLR) begin
                sel.tgt = TGT_GRP;
                sel.clr = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hisa_sticky_bank.sv
module hisa_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] d_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;

        // A set in the same cycle as a clear keeps the bit
        assign d_o[i] = set_i[i] | (bit_q & ~clr_i[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= d_o[i];
            end
        end

        assign q_o[i] = bit_q;
    end

endmodule

// File: rtl/hisa_read_port.sv
module hisa_read_port
    import hisa_pkg::*;
#(
    parameter int DW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [DW-1:0] word_i,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    rp_state_e     state_q;
    rp_state_e     state_d;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (rd_en)  state_d = RP_RESP;
            RP_RESP: if (!rd_en) state_d = RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= word_i;
        end
    end

    always_comb begin
        rd_valid = (state_q == RP_RESP);
        rd_data  = rd_valid ? data_q : '0;
    end

endmodule

// File: rtl/hisa_req_fsm.sv
module hisa_req_fsm
    import hisa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_next,
    output logic irq_n
);

    rq_state_e state_q;
    rq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_QUIET:    if (pend_next)  state_d = RQ_ASSERTED;
            RQ_ASSERTED: if (!pend_next) state_d = RQ_QUIET;
            default:     state_d = RQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n = (state_q != RQ_ASSERTED);
    end

endmodule

// File: rtl/hisa_irq_aggregator.sv
module hisa_irq_aggregator
    import hisa_pkg::*;
#(
    parameter int SW  = STAT_W,
    parameter int GW  = GRP_W,
    parameter int GB  = GRP_BIT,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] top_evt,
    input  logic [GW-1:0] grp_evt,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [SW-1:0] rd_data,
    output logic          irq_n
);

    localparam logic [SW-1:0] SUM_MASK = SW'(1) << GB;

    rd_sel_t       sel;
    logic [SW-1:0] top_set;
    logic [SW-1:0] top_clr;
    logic [SW-1:0] top_q;
    logic [SW-1:0] top_d;
    logic [GW-1:0] grp_clr;
    logic [GW-1:0] grp_q;
    logic [GW-1:0] grp_d;
    logic [SW-1:0] status_top;
    logic [GW-1:0] status_grp;
    logic [SW-1:0] word;
    logic          pend_next;

    hisa_rd_decode #(.AW(AW)) u_dec (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .sel     (sel)
    );

    always_comb begin
        top_set = top_evt & ~SUM_MASK;
        top_clr = ((sel.tgt == TGT_TOP) && sel.clr) ? ~SUM_MASK : '0;
        grp_clr = ((sel.tgt == TGT_GRP) && sel.clr) ? '1 : '0;
    end

    hisa_sticky_bank #(.W(SW)) u_top_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (top_set),
        .clr_i (top_clr),
        .q_o   (top_q),
        .d_o   (top_d)
    );

    hisa_sticky_bank #(.W(GW)) u_grp_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (grp_evt),
        .clr_i (grp_clr),
        .q_o   (grp_q),
        .d_o   (grp_d)
    );

    always_comb begin
        status_grp = grp_q;
        status_top = (top_q & ~SUM_MASK) | ((|grp_q) ? SUM_MASK : '0);
        unique case (sel.tgt)
            TGT_TOP: word = status_top;
            TGT_GRP: word = SW'(status_grp);
            default: word = '0;
        endcase
        pend_next = (|(top_d & ~SUM_MASK)) | (|grp_d);
    end

    hisa_read_port #(.DW(SW)) u_rport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .word_i   (word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    hisa_req_fsm u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_next (pend_next),
        .irq_n     (irq_n)
    );

endmodule

// File: rtl/hisa_irq_aggregator_chk.sv
module hisa_irq_aggregator_chk
    import hisa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] top_evt,
    input logic [GRP_W-1:0]  grp_evt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [STAT_W-1:0] rd_data,
    input logic              irq_n,
    input logic [STAT_W-1:0] status_top,
    input logic [GRP_W-1:0]  status_grp
);

    localparam logic [STAT_W-1:0] NSUM = ~(STAT_W'(1) << GRP_BIT);

    p_resp_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_spurious_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_top != '0) |-> !irq_n);

    p_irq_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_top == '0) |-> irq_n);

    p_grp_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_evt != '0) |=> ((status_grp & $past(grp_evt)) == $past(grp_evt)));

    p_top_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_evt & NSUM) != '0) |=>
            ((status_top & $past(top_evt & NSUM)) == $past(top_evt & NSUM)));

    p_grp_mirror_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(OFF_GRP_MIR)) |=>
            ((status_grp & $past(status_grp)) == $past(status_grp)));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_W'(OFF_GRP_MIR) || rd_addr == ADDR_W'(OFF_GRP_CLR)))
            |=> (rd_data[STAT_W-1:GRP_W] == '0));

    p_sum_input_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_evt[GRP_BIT] && grp_evt == '0 && status_grp == '0) |=> !status_top[GRP_BIT]);

endmodule

bind hisa_irq_aggregator hisa_irq_aggregator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .top_evt    (top_evt),
    .grp_evt    (grp_evt),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .irq_n      (irq_n),
    .status_top (status_top),
    .status_grp (status_grp)
);

// File: tb/hisa_irq_aggregator_tb.sv
module hisa_irq_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] top_evt = '0;
    logic [5:0]  grp_evt = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    hisa_irq_aggregator u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .top_evt  (top_evt),
        .grp_evt  (grp_evt),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .irq_n    (irq_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data when a response appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R8: actual unexpected response %h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: issue a read, optionally with event pulses in the same cycle
    task automatic do_read_ev(input logic [7:0] a, input logic [15:0] exp, input string tag,
                              input logic [15:0] tev, input logic [5:0] gev);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        top_evt = tev;
        grp_evt = gev;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        check({tag, " R8 valid"}, {15'd0, rd_valid}, 16'd1);
        rd_en   = 1'b0;
        top_evt = '0;
        grp_evt = '0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        do_read_ev(a, exp, tag, 16'h0, 6'h0);
    endtask

    task automatic pulse(input logic [15:0] tev, input logic [5:0] gev);
        @(negedge clk);
        top_evt = tev;
        grp_evt = gev;
        @(negedge clk);
        top_evt = '0;
        grp_evt = '0;
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected completion");
                    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq_n", {15'd0, irq_n}, 16'd1);
        check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
        do_read(8'h00, 16'h0000, "R1 top empty");
        do_read(8'h04, 16'h0000, "R1 grp empty");

        // R2/R3/R9: timer 1 event
        pulse(16'h0, 6'h01);
        check("R9 irq low", {15'd0, irq_n}, 16'd0);
        do_read(8'h04, 16'h0001, "R2 grp timer1");
        do_read(8'h00, 16'h0200, "R3 summary bit");
        do_read(8'h04, 16'h0001, "R4 grp mirror kept");

        // R5: clearing the top keeps the summary
        do_read(8'h02, 16'h0200, "R5 top clear read");
        do_read(8'h00, 16'h0200, "R5 summary held");
        check("R9 irq still low", {15'd0, irq_n}, 16'd0);

        // R6/R9: clear group
        do_read(8'h06, 16'h0001, "R6 grp clear read");
        check("R9 irq released", {15'd0, irq_n}, 16'd1);
        do_read(8'h00, 16'h0000, "R6 summary dropped");

        // R3/R4/R5: independent top sources
        pulse(16'h8001, 6'h0);
        do_read(8'h00, 16'h8001, "R3 top sources");
        do_read(8'h00, 16'h8001, "R4 top mirror kept");
        do_read(8'h02, 16'h8001, "R5 top clear read");
        do_read(8'h00, 16'h0000, "R5 top cleared");
        check("R9 irq after top clear", {15'd0, irq_n}, 16'd1);

        // R10: summary position of top input ignored
        pulse(16'h0200, 6'h0);
        check("R10 irq untouched", {15'd0, irq_n}, 16'd1);
        do_read(8'h00, 16'h0000, "R10 no bit set");

        // R11: unmapped addresses; bus trap and user trap 3
        pulse(16'h0, 6'h24);
        do_read(8'h08, 16'h0000, "R11 addr 08");
        do_read(8'h03, 16'h0000, "R11 addr 03");
        do_read(8'h04, 16'h0024, "R11 grp intact");

        // R7: group event collides with clearing read
        do_read_ev(8'h06, 16'h0024, "R7 grp old data", 16'h0, 6'h01);
        check("R7 irq held", {15'd0, irq_n}, 16'd0);
        do_read(8'h04, 16'h0001, "R7 grp event kept");
        do_read(8'h06, 16'h0001, "R7 grp final clear");
        check("R9 irq released again", {15'd0, irq_n}, 16'd1);

        // R7: top event collides with clearing read
        do_read_ev(8'h02, 16'h0000, "R7 top old data", 16'h0004, 6'h0);
        do_read(8'h00, 16'h0004, "R7 top event kept");
        do_read(8'h02, 16'h0004, "R7 top final clear");
        check("R9 irq idle", {15'd0, irq_n}, 16'd1);

        // R8: back-to-back reads
        pulse(16'h0400, 6'h02);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h00;
        exp_q.push_back(16'h0600); tag_q.push_back("R8 burst 1");
        @(negedge clk);
        rd_addr = 8'h06;
        exp_q.push_back(16'h0002); tag_q.push_back("R8 burst 2");
        @(negedge clk);
        rd_addr = 8'h02;
        exp_q.push_back(16'h0400); tag_q.push_back("R8 burst 3");
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check("R8 valid drops", {15'd0, rd_valid}, 16'd0);
        check("R9 irq after burst", {15'd0, irq_n}, 16'd1);
        check("R8 queue drained", 16'(exp_q.size()), 16'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule